// File: doc/BRIEF.md
# Two-Word Burst Synchronous SRAM Core

This block models a synchronous static RAM with separate write and read data paths in which every access moves exactly two words. It runs at fabric rate. On each rising clock edge it registers an active-low load strobe, a read/write select, a burst address and the byte-write enables. The two words of a burst, which on a double-rate bus would travel on the two halves of a clock period, are carried here as one double-width beat. The lower half holds the first word and the upper half the second.

A burst address `A` selects the word pair at internal word indexes `{A,0}` (first word) and `{A,1}` (second word). A write stores the two words of the beat, lane by lane, under active-low byte-write enables that each cover one 9-bit lane. A read returns both words as one output beat a fixed number of cycles later, together with a valid flag that marks the beat. With the strobe high the cycle is a no-operation. A small controller moves between idle, read-burst and write-burst states.

Top module: `ddr2b_sram`

## Requirements
- R1: Synchronous active-high `rst` puts the controller in idle and discards every read in flight. From the first cycle after a reset edge, `rvalid` is 0 and `rdata` is 0 until a new read is loaded.
- R2: A load with `ld_n`=0 and `rd_wr`=0 and all `bw_n` bits 0 stores `wdata[DATA_W-1:0]` at word `{addr,0}` and `wdata[2*DATA_W-1:DATA_W]` at word `{addr,1}`. A later read of `addr` returns the first word in `rdata[DATA_W-1:0]` and the second in the upper half.
- R3: A read loaded with `ld_n`=0 and `rd_wr`=1 at clock edge n makes `rvalid` 1 with its data for exactly the one cycle after edge n+RD_LAT (default RD_LAT=2).
- R4: With `ld_n`=1 the cycle is a no-operation whatever `rd_wr`, `addr`, `bw_n` and `wdata` hold. No word changes and no read is produced.
- R5: Byte-write bit `bw_n[w*LANES+i]` (LANES = DATA_W/9), when 0, writes bits `9*i+8:9*i` of burst word w. Lanes whose bit is 1 keep their old contents.
- R6: A write load with every `bw_n` bit 1 leaves both words of the pair unchanged.
- R7: Reads loaded on consecutive edges return their beats on consecutive cycles, in load order, each with `rvalid` 1.
- R8: A read loaded on the edge right after a write to the same address returns the newly merged data, byte masks included.
- R9: Reset leaves the memory contents unchanged.
- R10: While `rvalid` is 0, `rdata` is all zeros.
- R11: A load on any edge starts the next burst at once, whether the block was idle, reading or writing. A cycle without a load returns the controller to idle. Reads, writes and idle cycles can be mixed on consecutive edges with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all inputs registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low load strobe; high means no-operation |
| rd_wr | input | 1 | 1 selects a read burst, 0 a write burst |
| addr | input | ADDR_W | Burst address of the word pair |
| bw_n | input | 2*DATA_W/9 | Active-low lane write enables, first word in the low half |
| wdata | input | 2*DATA_W | Write beat, first word in the low half |
| rdata | output | 2*DATA_W | Read beat, first word in the low half; zero when not valid |
| rvalid | output | 1 | Marks the cycle that carries a read beat |

## Verification
The main function is tried with full-lane writes at several addresses, crossed lane masks that write different lanes in each of the two words, fully masked writes, and no-operation cycles that carry write-like data. These tell a correct lane decode apart from swapped words, swapped lanes or an ignored strobe. Single reads separated by idle cycles pin down the latency exactly. Back-to-back reads show that the beats are not merged or reordered. A read that follows a write on the very next edge tells the write commit order apart from a stale read. A reset with a read in flight, followed by a read of data written before the reset, shows that reset clears the pipeline but not the array.

// File: rtl/ddr2b_sram_pkg.sv
package ddr2b_sram_pkg;
  // Width of one byte-write lane (8 data bits plus one extra bit)
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    BST_IDLE  = 2'd0,
    BST_READ  = 2'd1,
    BST_WRITE = 2'd2
  } bst_e;

  // Next controller state from the sampled strobe and select
  function automatic bst_e next_state(input logic ld_n, input logic rd_wr);
    if (ld_n) return BST_IDLE;
    return rd_wr ? BST_READ : BST_WRITE;
  endfunction
endpackage

// File: rtl/ddr2b_sram_ctrl.sv
module ddr2b_sram_ctrl
  import ddr2b_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 36,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_n,
  input  logic                  rd_wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANES-1:0]    bw_n,
  input  logic [2*DATA_W-1:0]   wdata,
  output bst_e                  state,
  output logic                  rd_go,
  output logic                  wr_go,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic [2*LANES-1:0]    cmd_bw_n,
  output logic [2*DATA_W-1:0]   cmd_wdata
);
  bst_e st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= BST_IDLE;
    else     st_q <= next_state(ld_n, rd_wr);
  end

  // Command registers; contents only matter while a burst is active
  always_ff @(posedge clk) begin
    cmd_addr  <= addr;
    cmd_bw_n  <= bw_n;
    cmd_wdata <= wdata;
  end

  assign state = st_q;
  assign rd_go = (st_q == BST_READ);
  assign wr_go = (st_q == BST_WRITE);

  AST_LOAD_STARTS_BURST: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (state != BST_IDLE)); // R11
  AST_NO_LOAD_IDLES: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> (state == BST_IDLE && !wr_go && !rd_go)); // R4
  AST_READ_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && rd_wr) |=> (rd_go && !wr_go)); // R11
endmodule

// File: rtl/ddr2b_sram_array.sv
module ddr2b_sram_array
  import ddr2b_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 36,
  localparam int LANES = DATA_W / LANE_W,
  localparam int WORDS = 2 ** (ADDR_W + 1)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANES-1:0]    bw_n,
  input  logic [2*DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  // Word index of burst word `second` at burst address a
  function automatic logic [ADDR_W:0] word_idx(input logic [ADDR_W-1:0] a, input logic second);
    return {a, second};
  endfunction

  // Replace only the lanes whose active-low enable is 0
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en_n);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (!en_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < 2; w++) begin
        mem[word_idx(addr, 1'(w))] <= lane_merge(mem[word_idx(addr, 1'(w))],
                                                 wdata[w*DATA_W +: DATA_W],
                                                 bw_n[w*LANES +: LANES]);
      end
    end
  end

  assign rdata = {mem[word_idx(addr, 1'b1)], mem[word_idx(addr, 1'b0)]};
endmodule

// File: rtl/ddr2b_sram_rdpipe.sv
module ddr2b_sram_rdpipe #(
  parameter int DEPTH = 2,
  parameter int W     = 72
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic         v_q [DEPTH];
  logic [W-1:0] d_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_v;
          d_q[0] <= in_v ? in_d : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[k] <= 1'b0;
          d_q[k] <= '0;
        end else begin
          v_q[k] <= v_q[k-1];
          d_q[k] <= d_q[k-1];
        end
      end
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !out_v |-> (out_d == '0)); // R10
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 36,   // 9, 18 or 36
  parameter int RD_LAT = 2,    // edges from load to read beat, at least 1
  localparam int LANES = DATA_W / LANE_W,
  localparam int CW    = $clog2(RD_LAT + 1) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_n,
  input  logic                  rd_wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANES-1:0]    bw_n,
  input  logic [2*DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0]   rdata,
  output logic                  rvalid
);
  bst_e                 state;
  logic                 rd_go, wr_go;
  logic [ADDR_W-1:0]    cmd_addr;
  logic [2*LANES-1:0]   cmd_bw_n;
  logic [2*DATA_W-1:0]  cmd_wdata;
  logic [2*DATA_W-1:0]  arr_rdata;

  ddr2b_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
    .bw_n(bw_n), .wdata(wdata), .state(state), .rd_go(rd_go), .wr_go(wr_go),
    .cmd_addr(cmd_addr), .cmd_bw_n(cmd_bw_n), .cmd_wdata(cmd_wdata)
  );

  ddr2b_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(wr_go), .addr(cmd_addr), .bw_n(cmd_bw_n),
    .wdata(cmd_wdata), .rdata(arr_rdata)
  );

  ddr2b_sram_rdpipe #(.DEPTH(RD_LAT), .W(2*DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .in_v(rd_go), .in_d(arr_rdata),
    .out_v(rvalid), .out_d(rdata)
  );

  // Reads accepted by the array but not yet delivered, for the checks below
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(rd_go) - CW'(rvalid);
  end

  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (inflight != '0)); // R3
  AST_INFLIGHT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(RD_LAT)); // R7
  AST_ONE_BURST_KIND: assert property (@(posedge clk) disable iff (rst)
    !(rd_go && wr_go)); // R11
endmodule

// File: tb/ddr2b_sram_tb_top.sv
`timescale 1ns/1ps
module ddr2b_sram_tb_top;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 36;
  localparam int RD_LAT = 2;
  localparam int LANES  = DATA_W / 9;
  localparam int BW     = 2 * DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_n = 1'b1;
  logic              rd_wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2*LANES-1:0] bw_n = '1;
  logic [BW-1:0]     wdata = '0;
  logic [BW-1:0]     rdata;
  logic              rvalid;

  always #5 clk = ~clk;

  ddr2b_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
    .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_req = "R1";
  logic [DATA_W-1:0] model [2**(ADDR_W+1)];
  logic              exp_v [64];
  logic [BW-1:0]     exp_d [64];

  function automatic logic [BW-1:0] model_read(input logic [ADDR_W-1:0] a);
    return {model[{a, 1'b1}], model[{a, 1'b0}]};
  endfunction

  // One clock: drive at the falling edge, commit at the rising edge, compare at the next falling edge
  task automatic step(input logic r, input logic l, input logic rw,
                      input logic [ADDR_W-1:0] a, input logic [2*LANES-1:0] b,
                      input logic [BW-1:0] d);
    rst = r; ld_n = l; rd_wr = rw; addr = a; bw_n = b; wdata = d;
    @(posedge clk);
    cyc++;
    if (r) begin
      for (int s = 0; s < 64; s++) begin exp_v[s] = 1'b0; exp_d[s] = '0; end
    end else if (!l) begin
      if (rw) begin
        exp_v[(cyc + RD_LAT) % 64] = 1'b1;
        exp_d[(cyc + RD_LAT) % 64] = model_read(a);
      end else begin
        for (int w = 0; w < 2; w++)
          for (int i = 0; i < LANES; i++)
            if (!b[w*LANES+i]) model[{a, 1'(w)}][i*9 +: 9] = d[w*DATA_W + i*9 +: 9];
      end
    end
    @(negedge clk);
    checks++;
    if (rvalid !== exp_v[cyc % 64] || rdata !== exp_d[cyc % 64]) begin
      fails++;
      $display("FAIL %s cycle %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               cur_req, cyc, rvalid, rdata, exp_v[cyc % 64], exp_d[cyc % 64]);
    end
    exp_v[cyc % 64] = 1'b0;
    exp_d[cyc % 64] = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1, 1'b0, '0, '1, '0);
  endtask
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [2*LANES-1:0] b, input logic [BW-1:0] d);
    step(1'b0, 1'b0, 1'b0, a, b, d);
  endtask
  task automatic rd(input logic [ADDR_W-1:0] a);
    step(1'b0, 1'b0, 1'b1, a, '1, '0);
  endtask

  task automatic t_reset();           // R1: quiet outputs after reset
    cur_req = "R1";
    step(1'b1, 1'b1, 1'b0, '0, '1, '0);
    step(1'b1, 1'b1, 1'b0, '0, '1, '0);
    idle(2);
  endtask

  task automatic t_write_read();      // R2: word order and address independence
    cur_req = "R2";
    wr(5'd3,  '0, {36'h1_2345_6789, 36'hA_BCDE_F012});
    wr(5'd10, '0, {36'hF_0F0F_0F0F, 36'h0_1234_5678});
    wr(5'd31, '0, {36'h8_0000_0001, 36'h7_FFFF_FFFE});
    rd(5'd3); idle(1); rd(5'd10); idle(1); rd(5'd31);
    idle(RD_LAT + 1);
  endtask

  task automatic t_latency();         // R3: one beat exactly RD_LAT edges after load
    cur_req = "R3";
    rd(5'd10);
    idle(RD_LAT + 2);
  endtask

  task automatic t_nop();             // R4: strobe high ignores write-like inputs
    cur_req = "R4";
    step(1'b0, 1'b1, 1'b0, 5'd3, '0, {BW{1'b1}});
    step(1'b0, 1'b1, 1'b1, 5'd3, '0, '0);
    rd(5'd3);
    idle(RD_LAT + 1);
  endtask

  task automatic t_lanes();           // R5: crossed lane masks per word
    cur_req = "R5";
    wr(5'd5, '0, {36'h1_1111_1111, 36'h2_2222_2222});
    wr(5'd5, 8'b1010_0101, {36'hE_EEEE_EEEE, 36'hD_DDDD_DDDD});
    idle(1); rd(5'd5);
    wr(5'd5, 8'b0111_1110, {36'h3_3333_3333, 36'h4_4444_4444});
    idle(1); rd(5'd5);
    idle(RD_LAT + 1);
  endtask

  task automatic t_nowrite();         // R6: all enables high stores nothing
    cur_req = "R6";
    wr(5'd10, '1, {BW{1'b0}});
    idle(1); rd(5'd10);
    idle(RD_LAT + 1);
  endtask

  task automatic t_stream();          // R7: back-to-back reads
    cur_req = "R7";
    rd(5'd3); rd(5'd10); rd(5'd5); rd(5'd31);
    idle(RD_LAT + 1);
  endtask

  task automatic t_raw();             // R8: read right after write sees merged data
    cur_req = "R8";
    wr(5'd7, '0, {36'h5_5555_5555, 36'h6_6666_6666});
    wr(5'd7, 8'b1100_0011, {36'h9_8765_4321, 36'h0_FEDC_BA98});
    rd(5'd7);
    wr(5'd7, 8'b0011_1111, {36'hA_AAAA_AAAA, 36'hB_BBBB_BBBB});
    rd(5'd7);
    idle(RD_LAT + 1);
  endtask

  task automatic t_reset_keep();      // R9 and R1: reset drops a read in flight, keeps memory
    cur_req = "R9";
    rd(5'd3);
    step(1'b1, 1'b1, 1'b0, '0, '1, '0);
    idle(RD_LAT + 1);
    rd(5'd3); rd(5'd7);
    idle(RD_LAT + 1);
  endtask

  task automatic t_mix();             // R11 and R10: burst-to-burst with idle gaps
    cur_req = "R11";
    wr(5'd12, '0, {36'hC_0000_000C, 36'h0_C0C0_C0C0});
    rd(5'd12);
    wr(5'd13, '0, {36'h1_3131_3131, 36'h3_1313_1313});
    rd(5'd13);
    idle(1);
    rd(5'd12);
    cur_req = "R10";
    idle(RD_LAT + 2);
  endtask

  initial begin
    for (int s = 0; s < 64; s++) begin exp_v[s] = 1'b0; exp_d[s] = '0; end
    @(negedge clk);
    t_reset();
    t_write_read();
    t_latency();
    t_nop();
    t_lanes();
    t_nowrite();
    t_stream();
    t_raw();
    t_reset_keep();
    t_mix();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL %s watchdog expired: actual=running expected=finished", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule